// File: doc/BRIEF.md
# Eight-bit Accumulator ALU with Status Flags

This block is the purely combinational arithmetic and logic stage of a classic accumulator processor. Each evaluation takes a 4-bit operation code, the accumulator value (or the index register value for a compare), a memory or immediate operand, and the current status byte. It returns a data result and a new status byte. Every operation follows its own flag rules. Flags that an operation does not touch come through unchanged.

Single-operand operations act on the operand input: shifts, rotates, increment and decrement. To operate on the accumulator itself, the caller routes the accumulator to that input. Compare and the two bit-test operations produce no new data, so the result output returns the accumulator input unchanged. The test-and-set and test-and-clear operations take their zero flag from one value and return a different value, which the caller writes back to memory. Decimal correction is reserved behind a parameter. In the present variants, addition and subtraction are always binary.

Top module: `acc_alu`

## Requirements
- R1: Status byte layout: N bit 7, V bit 6, B bit 4, D bit 3, I bit 2, Z bit 1, C bit 0. Every operation passes bits 5, 4, 3 and 2 through unchanged.
- R2: Add (code 0) returns A + operand + C. C is the carry out. V is set when both inputs have the same sign and the result has the other sign. N is result bit 7. Z is set when the result is zero.
- R3: Subtract (code 1) returns A − operand − (1 − C). C is set when no borrow occurs. V is set on signed overflow. N and Z follow the result.
- R4: AND (code 2), OR (code 3) and XOR (code 4) return the bitwise result. They update only N and Z.
- R5: Shift left (code 5) puts 0 into bit 0 and bit 7 into C. Shift right (code 6) puts 0 into bit 7 and bit 0 into C, and always clears N. Both update N and Z from the result and leave V unchanged.
- R6: Rotate left (code 7) and rotate right (code 8) form a 9-bit loop through C. Rotate left puts the old C into bit 0 and bit 7 into C. Rotate right puts the old C into bit 7 and bit 0 into C. Both update N and Z and leave V unchanged.
- R7: Increment (code 9) and decrement (code 10) return the operand plus or minus one, wrapping modulo 256. They update only N and Z, and C and V keep their values.
- R8: Compare (code 11) forms A − operand. It sets C when A ≥ operand, sets Z when they are equal, and copies bit 7 of the difference into N. V is unchanged and the result output equals A.
- R9: Bit test, memory form (code 12), sets Z when A AND operand is zero and copies operand bits 7 and 6 into N and V. C is unchanged and the result output equals A.
- R10: Bit test, immediate form (code 13), changes only Z, which is set when A AND operand is zero. The result output equals A.
- R11: Test-and-set (code 14) returns operand OR A. Test-and-clear (code 15) returns operand AND NOT A. Both set Z when A AND operand is zero, and change no other flag.
- R12: The D flag has no effect on addition or subtraction: the result and flags are the binary ones whether D is 0 or 1, for either setting of the decimal parameter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| acc_i | input | DW | Accumulator or index register operand |
| opnd_i | input | DW | Memory or immediate operand |
| stat_i | input | 8 | Incoming status byte |
| res_o | output | DW | Data result |
| stat_o | output | 8 | Updated status byte |

## Verification
The bench builds two instances at the default 8-bit data width: one with the decimal parameter at 0 and one with it at 1. Both are compared with the same behavioural model, so either variant can reach every operation code, and R12 holds on both paths. Because the width is 8, the inputs are small enough that sign boundaries (0x7F/0x80), carry out of 0xFF, and zero results can be hit deliberately. Thousands of random operand and status combinations then cover each operation code.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_ASL  = 4'd5,
    OP_LSR  = 4'd6,
    OP_ROL  = 4'd7,
    OP_ROR  = 4'd8,
    OP_INC  = 4'd9,
    OP_DEC  = 4'd10,
    OP_CMP  = 4'd11,
    OP_BITM = 4'd12,
    OP_BITI = 4'd13,
    OP_TSB  = 4'd14,
    OP_TRB  = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    LF_AND    = 2'd0,
    LF_OR     = 2'd1,
    LF_XOR    = 2'd2,
    LF_ANDNOT = 2'd3
  } logic_fn_e;

  localparam int STAT_W = 8;
  localparam int FL_C   = 0;
  localparam int FL_Z   = 1;
  localparam int FL_V   = 6;
  localparam int FL_N   = 7;

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int DW     = 8,
  parameter bit DEC_EN = 1'b0
) (
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic          cin_i,
  output logic [DW-1:0] sum_o,
  output logic          cout_o,
  output logic          ovf_o
);

  localparam int WW = DW + 1;

  logic [WW-1:0] wide;
  logic [DW-1:0] bin_sum;

  assign wide    = {1'b0, x_i} + {1'b0, y_i} + {{DW{1'b0}}, cin_i};
  assign bin_sum = wide[DW-1:0];
  assign cout_o  = wide[DW];
  // signed overflow: like-signed inputs, opposite-signed sum
  assign ovf_o   = (x_i[DW-1] == y_i[DW-1]) && (bin_sum[DW-1] != x_i[DW-1]);

  generate
    if (DEC_EN) begin : g_dec_stub
      // placeholder for decimal correction; binary path for now
      assign sum_o = bin_sum;
    end else begin : g_bin
      assign sum_o = bin_sum;
    end
  endgenerate

endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] val_i,
  input  logic          left_i,
  input  logic          rotate_i,
  input  logic          cin_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o
);

  logic fill;

  assign fill = rotate_i & cin_i;

  always_comb begin
    if (left_i) begin
      res_o  = {val_i[DW-2:0], fill};
      cout_o = val_i[DW-1];
    end else begin
      res_o  = {fill, val_i[DW-1:1]};
      cout_o = val_i[0];
    end
  end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic_fn_e     fn_i,
  output logic [DW-1:0] res_o,
  output logic [DW-1:0] mask_o
);

  assign mask_o = a_i & b_i;

  always_comb begin
    unique case (fn_i)
      LF_AND:    res_o = a_i & b_i;
      LF_OR:     res_o = a_i | b_i;
      LF_XOR:    res_o = a_i ^ b_i;
      LF_ANDNOT: res_o = b_i & ~a_i;
      default:   res_o = a_i & b_i;
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW     = 8,
  parameter bit DEC_EN = 1'b0
) (
  input  logic [3:0]        op_i,
  input  logic [DW-1:0]     acc_i,
  input  logic [DW-1:0]     opnd_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic [DW-1:0]     res_o,
  output logic [STAT_W-1:0] stat_o
);

  localparam int MSB  = DW - 1;
  localparam int MSB2 = DW - 2;

  alu_op_e       op;
  logic [DW-1:0] ax, ay;
  logic          acin;
  logic [DW-1:0] sum;
  logic          cout, ovf;
  logic          sh_left, sh_rot;
  logic [DW-1:0] sh_res;
  logic          sh_c;
  logic_fn_e     lfn;
  logic [DW-1:0] l_res, l_mask;

  assign op = alu_op_e'(op_i);

  // adder operand steering
  always_comb begin
    ax   = acc_i;
    ay   = opnd_i;
    acin = stat_i[FL_C];
    unique case (op)
      OP_SUB: ay = ~opnd_i;
      OP_CMP: begin
        ay   = ~opnd_i;
        acin = 1'b1;
      end
      OP_INC: begin
        ax   = opnd_i;
        ay   = '0;
        acin = 1'b1;
      end
      OP_DEC: begin
        ax   = opnd_i;
        ay   = '1;
        acin = 1'b0;
      end
      default: ;
    endcase
  end

  assign sh_left = (op == OP_ASL) || (op == OP_ROL);
  assign sh_rot  = (op == OP_ROL) || (op == OP_ROR);

  always_comb begin
    unique case (op)
      OP_OR, OP_TSB: lfn = LF_OR;
      OP_XOR:        lfn = LF_XOR;
      OP_TRB:        lfn = LF_ANDNOT;
      default:       lfn = LF_AND;
    endcase
  end

  acc_alu_arith #(.DW(DW), .DEC_EN(DEC_EN)) u_arith (
    .x_i(ax), .y_i(ay), .cin_i(acin),
    .sum_o(sum), .cout_o(cout), .ovf_o(ovf)
  );

  acc_alu_shift #(.DW(DW)) u_shift (
    .val_i(opnd_i), .left_i(sh_left), .rotate_i(sh_rot),
    .cin_i(stat_i[FL_C]), .res_o(sh_res), .cout_o(sh_c)
  );

  acc_alu_logic #(.DW(DW)) u_logic (
    .a_i(acc_i), .b_i(opnd_i), .fn_i(lfn),
    .res_o(l_res), .mask_o(l_mask)
  );

  // result select and per-operation flag rules
  always_comb begin
    logic upd_nz;
    res_o  = acc_i;
    stat_o = stat_i;
    upd_nz = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB: begin
        res_o        = sum;
        stat_o[FL_C] = cout;
        stat_o[FL_V] = ovf;
        upd_nz       = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res_o  = l_res;
        upd_nz = 1'b1;
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        res_o        = sh_res;
        stat_o[FL_C] = sh_c;
        upd_nz       = 1'b1;
      end
      OP_INC, OP_DEC: begin
        res_o  = sum;
        upd_nz = 1'b1;
      end
      OP_CMP: begin
        stat_o[FL_C] = cout;
        stat_o[FL_Z] = ~|sum;
        stat_o[FL_N] = sum[MSB];
      end
      OP_BITM: begin
        stat_o[FL_Z] = ~|l_mask;
        stat_o[FL_N] = opnd_i[MSB];
        stat_o[FL_V] = opnd_i[MSB2];
      end
      OP_BITI: stat_o[FL_Z] = ~|l_mask;
      OP_TSB, OP_TRB: begin
        res_o        = l_res;
        stat_o[FL_Z] = ~|l_mask;
      end
      default: ;
    endcase
    if (upd_nz) begin
      stat_o[FL_N] = res_o[MSB];
      stat_o[FL_Z] = ~|res_o;
    end
  end

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input logic [3:0]        op_i,
  input logic [DW-1:0]     acc_i,
  input logic [DW-1:0]     opnd_i,
  input logic [STAT_W-1:0] stat_i,
  input logic [DW-1:0]     res_o,
  input logic [STAT_W-1:0] stat_o
);

  alu_op_e op;
  logic    writes_nz;

  assign op = alu_op_e'(op_i);
  assign writes_nz = (op_i <= 4'd10);

  always_comb begin
    p_ctrl_bits_kept_r1: assert (stat_o[5:2] == stat_i[5:2])
      else $error("control bits altered");
    if (writes_nz) begin
      p_zero_flag_r2: assert (stat_o[FL_Z] == (res_o == '0))
        else $error("Z does not match result");
      p_neg_flag_r3: assert (stat_o[FL_N] == res_o[DW-1])
        else $error("N does not match result");
    end
    if (op == OP_AND || op == OP_OR || op == OP_XOR) begin
      p_logic_keep_cv_r4: assert (stat_o[FL_C] == stat_i[FL_C] && stat_o[FL_V] == stat_i[FL_V])
        else $error("logic op changed C or V");
    end
    if (op == OP_LSR) begin
      p_lsr_n_clear_r5: assert (!stat_o[FL_N] && stat_o[FL_C] == opnd_i[0])
        else $error("shift right flags wrong");
    end
    if (op == OP_ROL) begin
      p_rol_loop_r6: assert (res_o[0] == stat_i[FL_C] && stat_o[FL_C] == opnd_i[DW-1])
        else $error("rotate left loop broken");
    end
    if (op == OP_INC || op == OP_DEC) begin
      p_incdec_keep_cv_r7: assert (stat_o[FL_C] == stat_i[FL_C] && stat_o[FL_V] == stat_i[FL_V])
        else $error("inc/dec changed C or V");
    end
    if (op == OP_CMP) begin
      p_cmp_no_write_r8: assert (res_o == acc_i && stat_o[FL_V] == stat_i[FL_V]
                                 && stat_o[FL_C] == (acc_i >= opnd_i))
        else $error("compare wrote result or bad flags");
    end
    if (op == OP_BITM) begin
      p_bit_nv_copy_r9: assert (stat_o[FL_N] == opnd_i[DW-1] && stat_o[FL_V] == opnd_i[DW-2])
        else $error("bit test N/V not copied");
    end
    if (op == OP_BITI) begin
      p_biti_only_z_r10: assert ((stat_o & ~8'h02) == (stat_i & ~8'h02))
        else $error("immediate bit test changed more than Z");
    end
    if (op == OP_TSB || op == OP_TRB) begin
      p_tsb_trb_z_r11: assert (stat_o[FL_Z] == ((acc_i & opnd_i) == '0))
        else $error("test-and-modify Z wrong");
    end
  end

endmodule

bind acc_alu acc_alu_chk #(.DW(DW)) u_chk (
  .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i), .stat_i(stat_i),
  .res_o(res_o), .stat_o(stat_o)
);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;

  logic       clk;
  logic       rst_n;
  logic [3:0] op;
  logic [7:0] acc, opnd, st;
  logic [7:0] res0, st0, res1, st1;
  int         n_tests;
  int         n_fail;
  bit         finished;

  acc_alu #(.DW(8), .DEC_EN(1'b0)) u_acc_alu (
    .op_i(op), .acc_i(acc), .opnd_i(opnd), .stat_i(st),
    .res_o(res0), .stat_o(st0)
  );

  acc_alu #(.DW(8), .DEC_EN(1'b1)) u_acc_alu_dec (
    .op_i(op), .acc_i(acc), .opnd_i(opnd), .stat_i(st),
    .res_o(res1), .stat_o(st1)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int sgn(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // behavioural model: returns {result, status}
  function automatic logic [15:0] model(int o, int a, int b, logic [7:0] s_in);
    int r, t, c;
    logic [7:0] s;
    s = s_in;
    c = s_in[0];
    r = a;
    case (o)
      0: begin
        t = a + b + c; r = t % 256; s[0] = (t > 255);
        t = sgn(a) + sgn(b) + c; s[6] = (t > 127) || (t < -128);
      end
      1: begin
        t = a - b - (1 - c); r = (t + 256) % 256; s[0] = (t >= 0);
        t = sgn(a) - sgn(b) - (1 - c); s[6] = (t > 127) || (t < -128);
      end
      2: r = a & b;
      3: r = a | b;
      4: r = a ^ b;
      5: begin r = (b * 2) % 256; s[0] = (b >= 128); end
      6: begin r = b / 2; s[0] = (b % 2 == 1); end
      7: begin r = (b * 2) % 256 + c; s[0] = (b >= 128); end
      8: begin r = b / 2 + c * 128; s[0] = (b % 2 == 1); end
      9: r = (b + 1) % 256;
      10: r = (b + 255) % 256;
      11: begin
        t = a - b; s[0] = (t >= 0); s[1] = (t == 0);
        s[7] = (((t + 256) % 256) >= 128);
      end
      12: begin s[1] = ((a & b) == 0); s[7] = (b >= 128); s[6] = ((b / 64) % 2 == 1); end
      13: s[1] = ((a & b) == 0);
      14: begin r = a | b; s[1] = ((a & b) == 0); end
      default: begin r = b & (~a) & 255; s[1] = ((a & b) == 0); end
    endcase
    if (o <= 10) begin
      s[7] = (r >= 128);
      s[1] = (r == 0);
    end
    return {r[7:0], s};
  endfunction

  function automatic string tag_of(int o);
    case (o)
      0: return "R2";
      1: return "R3";
      2, 3, 4: return "R4";
      5, 6: return "R5";
      7, 8: return "R6";
      9, 10: return "R7";
      11: return "R8";
      12: return "R9";
      13: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check_now(string tag);
    logic [15:0] exp;
    exp = model(int'(op), int'(acc), int'(opnd), st);
    n_tests++;
    if ({res0, st0} !== exp || {res1, st1} !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h st=%h: got res=%h/%h st=%h/%h, expected res=%h st=%h",
               tag, op, acc, opnd, st, res0, res1, st0, st1, exp[15:8], exp[7:0]);
    end
  endtask

  task automatic apply(int o, int a, int b, int s, string tag);
    @(posedge clk);
    op = o[3:0]; acc = a[7:0]; opnd = b[7:0]; st = s[7:0];
    @(negedge clk);
    check_now(tag);
  endtask

  initial begin
    n_tests = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0;
    op = '0; acc = '0; opnd = '0; st = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // idle inputs: add of zeros gives zero result with Z set
    n_tests++;
    if (res0 !== 8'h00 || st0 !== 8'h02) begin
      n_fail++;
      $display("FAIL R2 reset state: got res=%h st=%h, expected res=00 st=02", res0, st0);
    end
    rst_n = 1'b1;

    // R1: control bits 5..2 survive every operation
    for (int o = 0; o < 16; o++) apply(o, 8'h5A, 8'hC3, 8'h3C, "R1");
    // R2 boundaries
    apply(0, 8'h7F, 8'h01, 8'h00, "R2");
    apply(0, 8'hFF, 8'h01, 8'h00, "R2");
    apply(0, 8'h80, 8'h80, 8'h01, "R2");
    // R3 boundaries
    apply(1, 8'h00, 8'h01, 8'h01, "R3");
    apply(1, 8'h80, 8'h01, 8'h01, "R3");
    apply(1, 8'h05, 8'h05, 8'h00, "R3");
    // R4
    apply(2, 8'hF0, 8'h0F, 8'hC1, "R4");
    apply(4, 8'hAA, 8'hAA, 8'h41, "R4");
    // R5
    apply(5, 8'h00, 8'h80, 8'h00, "R5");
    apply(6, 8'h00, 8'h01, 8'hC0, "R5");
    // R6
    apply(7, 8'h00, 8'h80, 8'h01, "R6");
    apply(8, 8'h00, 8'h01, 8'h01, "R6");
    // R7 wrap and C/V kept
    apply(9, 8'h00, 8'hFF, 8'h41, "R7");
    apply(10, 8'h00, 8'h00, 8'h40, "R7");
    // R8
    apply(11, 8'h40, 8'h40, 8'h40, "R8");
    apply(11, 8'h10, 8'h20, 8'h01, "R8");
    // R9 / R10
    apply(12, 8'h0F, 8'hC0, 8'h00, "R9");
    apply(13, 8'h0F, 8'hC0, 8'h00, "R10");
    // R11
    apply(14, 8'h0F, 8'hF0, 8'h00, "R11");
    apply(15, 8'h0F, 8'hFF, 8'h00, "R11");
    // R12: D set does not change add or subtract
    apply(0, 8'h09, 8'h01, 8'h08, "R12");
    apply(1, 8'h10, 8'h01, 8'h09, "R12");

    for (int i = 0; i < 4000; i++) begin
      int o;
      o = int'($urandom_range(0, 15));
      apply(o, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), tag_of(o));
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule